// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops normal execution and enters a hardware debug mode, and when it returns to run. External debug logic requests a stop by pulling an active-low run/stop pin low. A test access port instruction decoder can raise a debug-select level instead. Both requests take effect only at an instruction retirement boundary.

The pin request is a level and is never latched. It passes through a reset-to-run synchronizer. At use it is masked while the core is in a locked cycle, a special bus cycle, an interrupt acknowledge or the stop-clock state. A single higher-priority interrupt wins over the debug request at the same boundary.

Entry commits in a fixed order. First comes a one-cycle pipeline flush request. The block then waits for the pipeline to report empty. After that it raises a one-cycle ready acknowledge, and the debug-active flag rises together with it. Debug mode ends when the synchronized pin reads run and the debug-select level is gone.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, flush_req_o, ready_o and dbg_active_o are 0, and the block is in run.
- R2: A low level on run_stop_ni counts as a request only after it has been low at SYNC_STAGES consecutive rising clock edges. If a request is present in a cycle with retire_bnd_i high, flush_req_o is 1 in the next cycle.
- R3: Without retire_bnd_i high, a pending request never causes entry, no matter how long it is held.
- R4: A pin request that is released, and whose release has passed the synchronizer, before any boundary is lost. A later boundary then causes no entry.
- R5: If any of locked_i, special_i, intack_i or stop_clk_i is high in the boundary cycle, the pin request is ignored and no flush follows.
- R6: tap_dbg_sel_i high in a boundary cycle starts entry with no synchronizer delay. This path is not masked by the four gating inputs.
- R7: If hi_irq_i is high in the boundary cycle, no entry starts from either source.
- R8: flush_req_o is high for exactly one cycle. The block then waits with ready_o at 0 until pipe_empty_i is high. In the next cycle ready_o is 1 for one cycle, and dbg_active_o rises in that same cycle.
- R9: In debug mode, once run_stop_ni has been high at SYNC_STAGES rising edges and tap_dbg_sel_i is low, dbg_active_o is 0 from the following cycle.
- R10: In debug mode, the block stays in debug while the synchronized pin is low or tap_dbg_sel_i is high, and it issues no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_stop_ni | input | 1 | Run/stop request, low means stop; may be asynchronous |
| tap_dbg_sel_i | input | 1 | Debug-enter instruction selected in the TAP decoder |
| retire_bnd_i | input | 1 | Instruction retirement boundary strobe |
| locked_i | input | 1 | Locked bus cycle in progress |
| special_i | input | 1 | Special bus cycle in progress |
| intack_i | input | 1 | Interrupt acknowledge in progress |
| stop_clk_i | input | 1 | Core in stop-clock state |
| hi_irq_i | input | 1 | Pending interrupt that outranks the debug request |
| pipe_empty_i | input | 1 | Pipeline reports no instructions left |
| flush_req_o | output | 1 | One-cycle pipeline invalidate request |
| dbg_active_o | output | 1 | Debug mode active |
| ready_o | output | 1 | One-cycle ready acknowledge |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It sweeps all 32 combinations of the four gating inputs and the higher-priority interrupt at a boundary. Every combination that enters is taken through the whole flush, wait, ready and exit sequence. The two-stage synchronizer makes the edge-exact latency of a request, a release and an exit short enough to probe cycle by cycle. This includes a request that is one stage short of recognition.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_ACK   = 2'd2,
    ST_DEBUG = 2'd3
  } dbg_state_e;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_req_arb.sv
module dbg_req_arb (
  input  logic pin_stop_i,
  input  logic tap_dbg_sel_i,
  input  logic retire_bnd_i,
  input  logic locked_i,
  input  logic special_i,
  input  logic intack_i,
  input  logic stop_clk_i,
  input  logic hi_irq_i,
  output logic commit_o
);
  logic sample_en;
  logic pin_req;
  logic any_req;

  // pin masked by bus-cycle type and clock state; TAP path is not
  assign sample_en = ~(locked_i | special_i | intack_i | stop_clk_i);
  assign pin_req   = pin_stop_i & sample_en;
  assign any_req   = pin_req | tap_dbg_sel_i;
  assign commit_o  = retire_bnd_i & any_req & ~hi_irq_i;
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic pipe_empty_i,
  input  logic release_i,
  output logic flush_req_o,
  output logic ready_o,
  output logic dbg_active_o
);
  dbg_state_e state_q, state_d;
  logic       ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    ready_d = 1'b0;
    unique case (state_q)
      ST_RUN:   if (commit_i) state_d = ST_FLUSH;
      ST_FLUSH: state_d = ST_ACK;
      ST_ACK: begin
        if (pipe_empty_i) begin
          state_d = ST_DEBUG;
          ready_d = 1'b1;
        end
      end
      ST_DEBUG: if (release_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  assign flush_req_o  = (state_q == ST_FLUSH);
  assign dbg_active_o = (state_q == ST_DEBUG);
  assign ready_o      = ready_q;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_stop_ni,
  input  logic tap_dbg_sel_i,
  input  logic retire_bnd_i,
  input  logic locked_i,
  input  logic special_i,
  input  logic intack_i,
  input  logic stop_clk_i,
  input  logic hi_irq_i,
  input  logic pipe_empty_i,
  output logic flush_req_o,
  output logic dbg_active_o,
  output logic ready_o
);
  logic pin_run_s;
  logic commit;
  logic release_dbg;

  dbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_stop_ni),
    .q_o   (pin_run_s)
  );

  dbg_req_arb i_arb (
    .pin_stop_i   (~pin_run_s),
    .tap_dbg_sel_i(tap_dbg_sel_i),
    .retire_bnd_i (retire_bnd_i),
    .locked_i     (locked_i),
    .special_i    (special_i),
    .intack_i     (intack_i),
    .stop_clk_i   (stop_clk_i),
    .hi_irq_i     (hi_irq_i),
    .commit_o     (commit)
  );

  assign release_dbg = pin_run_s & ~tap_dbg_sel_i;

  dbg_entry_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .pipe_empty_i(pipe_empty_i),
    .release_i   (release_dbg),
    .flush_req_o (flush_req_o),
    .ready_o     (ready_o),
    .dbg_active_o(dbg_active_o)
  );
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tap_dbg_sel_i,
  input logic retire_bnd_i,
  input logic locked_i,
  input logic special_i,
  input logic intack_i,
  input logic stop_clk_i,
  input logic hi_irq_i,
  input logic pipe_empty_i,
  input logic flush_req_o,
  input logic dbg_active_o,
  input logic ready_o
);
  AST_FLUSH_AFTER_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> $past(retire_bnd_i)) else $error("flush without boundary"); // R3
  AST_GATE_MASKS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && !$past(tap_dbg_sel_i)) |->
      !$past(locked_i | special_i | intack_i | stop_clk_i)) else $error("gated pin entered"); // R5
  AST_HI_IRQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> !$past(hi_irq_i)) else $error("entry over higher irq"); // R7
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |=> !flush_req_o) else $error("flush too long"); // R8
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o) else $error("ready too long"); // R8
  AST_READY_AFTER_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ($past(pipe_empty_i) && dbg_active_o)) else $error("ready misplaced"); // R8
  AST_ACTIVE_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_active_o) |-> ready_o) else $error("active without ready"); // R8
  AST_NO_FLUSH_IN_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_o |-> !flush_req_o) else $error("flush in debug"); // R10
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tap_dbg_sel_i(tap_dbg_sel_i),
  .retire_bnd_i (retire_bnd_i),
  .locked_i     (locked_i),
  .special_i    (special_i),
  .intack_i     (intack_i),
  .stop_clk_i   (stop_clk_i),
  .hi_irq_i     (hi_irq_i),
  .pipe_empty_i (pipe_empty_i),
  .flush_req_o  (flush_req_o),
  .dbg_active_o (dbg_active_o),
  .ready_o      (ready_o)
);

// File: tb/test_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module test_dbg_entry_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_stop_ni = 1'b1, tap_sel = 1'b0, bnd = 1'b0;
  logic locked = 1'b0, special = 1'b0, intack = 1'b0, stop_clk = 1'b0;
  logic hi_irq = 1'b0, pipe_empty = 1'b0;
  logic flush, active, ready;
  int   n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dbg_entry_ctrl #(.SYNC_STAGES(2)) i_dbg_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .run_stop_ni(run_stop_ni),
    .tap_dbg_sel_i(tap_sel), .retire_bnd_i(bnd), .locked_i(locked),
    .special_i(special), .intack_i(intack), .stop_clk_i(stop_clk),
    .hi_irq_i(hi_irq), .pipe_empty_i(pipe_empty), .flush_req_o(flush),
    .dbg_active_o(active), .ready_o(ready)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    run_stop_ni = 1'b1; tap_sel = 1'b0; bnd = 1'b0; hi_irq = 1'b0;
    {locked, special, intack, stop_clk} = 4'b0; pipe_empty = 1'b0;
    tick(4);
  endtask

  // from FLUSH cycle through ready and exit, pin as the only holder
  task automatic finish_entry(string req);
    bnd = 1'b0;
    tick(1);
    chk("R8", {req, " flush single"}, flush, 1'b0);
    tick(2);
    chk("R8", {req, " wait no ready"}, ready, 1'b0);
    chk("R8", {req, " wait not active"}, active, 1'b0);
    pipe_empty = 1'b1;
    tick(1);
    chk("R8", {req, " ready"}, ready, 1'b1);
    chk("R8", {req, " active"}, active, 1'b1);
    pipe_empty = 1'b0;
    tick(1);
    chk("R8", {req, " ready drop"}, ready, 1'b0);
    chk("R10", {req, " stays"}, active, 1'b1);
    run_stop_ni = 1'b1;
    tick(2);
    chk("R9", {req, " exit latency"}, active, 1'b1);
    tick(1);
    chk("R9", {req, " exit"}, active, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(1);
    chk("R1", "flush in reset", flush, 1'b0);
    chk("R1", "active in reset", active, 1'b0);
    chk("R1", "ready in reset", ready, 1'b0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1", "flush after reset", flush, 1'b0);
    chk("R1", "active after reset", active, 1'b0);

    // R2: one stage short of recognition
    run_stop_ni = 1'b0;
    tick(1);
    bnd = 1'b1;
    tick(1);
    chk("R2", "early boundary", flush, 1'b0);
    tick(1);
    chk("R2", "recognised boundary", flush, 1'b1);
    finish_entry("R2");
    idle();

    // R3: held request, no boundary
    run_stop_ni = 1'b0;
    tick(8);
    chk("R3", "no boundary", flush, 1'b0);
    chk("R3", "no boundary active", active, 1'b0);
    idle();

    // R4: released before boundary
    run_stop_ni = 1'b0;
    tick(3);
    run_stop_ni = 1'b1;
    tick(2);
    bnd = 1'b1;
    tick(1);
    chk("R4", "lost request", flush, 1'b0);
    idle();

    // R5 / R7 sweep: 4 gating inputs x higher irq
    for (int m = 0; m < 32; m++) begin
      logic exp_e;
      exp_e = (m[3:0] == 4'd0) && !m[4];
      {locked, special, intack, stop_clk} = m[3:0];
      hi_irq = m[4];
      run_stop_ni = 1'b0;
      tick(2);
      bnd = 1'b1;
      tick(1);
      chk(m[4] ? "R7" : "R5", $sformatf("sweep %0d flush", m), flush, exp_e);
      {locked, special, intack, stop_clk} = 4'b0;
      hi_irq = 1'b0;
      if (exp_e) finish_entry("R5");
      idle();
      chk("R5", $sformatf("sweep %0d idle", m), active, 1'b0);
    end

    // R6: TAP path, immediate and not gated
    {locked, special, intack, stop_clk} = 4'b1111;
    tap_sel = 1'b1;
    tick(1);
    chk("R6", "tap no boundary", flush, 1'b0);
    bnd = 1'b1;
    tick(1);
    chk("R6", "tap entry", flush, 1'b1);
    bnd = 1'b0;
    {locked, special, intack, stop_clk} = 4'b0;
    pipe_empty = 1'b1;
    tick(2);
    chk("R6", "tap active", active, 1'b1);
    // R10: tap keeps debug while pin reads run
    tick(5);
    chk("R10", "tap holds", active, 1'b1);
    chk("R10", "no flush in debug", flush, 1'b0);
    tap_sel = 1'b0;
    tick(1);
    chk("R9", "tap release", active, 1'b0);
    idle();

    // R7: higher irq blocks TAP entry too
    tap_sel = 1'b1; hi_irq = 1'b1; bnd = 1'b1;
    tick(1);
    chk("R7", "tap vs hi irq", flush, 1'b0);
    idle();

    // R10: pin low keeps debug, tap drop alone no exit
    run_stop_ni = 1'b0;
    tick(2);
    bnd = 1'b1;
    tick(1);
    bnd = 1'b0; pipe_empty = 1'b1;
    tick(2);
    chk("R10", "pin entry", active, 1'b1);
    bnd = 1'b1;
    tick(4);
    chk("R10", "pin holds", active, 1'b1);
    chk("R10", "boundary in debug", flush, 1'b0);
    idle();
    chk("R9", "final run", active, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule